// File: doc/BRIEF.md
# Three-Slot Receive Frame Queue with Selectable Overrun Policy

This block is the receive-side message queue of a CAN-style bus controller. The frame receiver hands it complete frames (identifier, data length code and up to eight payload bytes) with a one-cycle write strobe. The queue holds at most three frames. The oldest frame stays on a read port until the reader pulses a release strobe. Alongside the head frame the queue reports a valid bit, a 2-bit fill level, a full flag and a sticky overrun flag.

A policy input decides what happens when a frame arrives while all three slots are occupied and nothing is released in that cycle. In the default policy the newest stored frame is overwritten, so the two oldest frames survive. In locked policy the arriving frame is dropped and the queue contents do not change. Either way the overrun flag is raised and stays set until a dedicated clear strobe.

Top module: `msg_rx_fifo3`

## Requirements
- R1: After synchronous reset the fill level is 0, and the full flag, the overrun flag and the head-valid bit are all 0.
- R2: Frames leave in the order they were written. The fill level counts stored frames from 0 to 3, and the full flag is 1 exactly when the level is 3.
- R3: A release strobe while at least one frame is held removes the head frame. The next-oldest frame appears on the read port one cycle after the strobe, and the level drops by one.
- R4: With the policy input at 0 (replace newest), a write while full with no release overwrites the most recently stored frame. After writing frames 1 to 5 with no release, a drain yields 1, 2 and 5.
- R5: With the policy input at 1 (locked), a write while full with no release is discarded and the head frame is unchanged. After writing frames 1 to 5, a drain yields 1, 2 and 3.
- R6: Every write while full with no release in the same cycle sets the overrun flag on the next cycle. The flag stays set through releases and later writes until the clear strobe is pulsed. A clear in the same cycle as a new overrun leaves the flag set.
- R7: A write and a release in the same cycle while full perform the release first and then store the new frame. The level stays 3 and no overrun is flagged.
- R8: A release strobe while the queue is empty has no effect. A write and a release together on an empty queue store the frame, giving a level of 1.
- R9: An overrun never changes the fill level; it stays at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lock_mode_i | input | 1 | Overrun policy: 0 replaces the newest frame, 1 drops the arriving frame |
| wr_en_i | input | 1 | One-cycle strobe: store the frame on the wr_* inputs |
| wr_id_i | input | 29 | Identifier of the incoming frame |
| wr_dlc_i | input | 4 | Data length code of the incoming frame |
| wr_data_i | input | 64 | Payload of the incoming frame |
| rel_i | input | 1 | One-cycle strobe: release the head frame |
| ovr_clr_i | input | 1 | One-cycle strobe: clear the sticky overrun flag |
| rd_valid_o | output | 1 | A head frame is present |
| rd_id_o | output | 29 | Identifier of the head frame (0 when empty) |
| rd_dlc_o | output | 4 | Data length code of the head frame (0 when empty) |
| rd_data_o | output | 64 | Payload of the head frame (0 when empty) |
| level_o | output | 2 | Number of stored frames, 0 to 3 |
| full_o | output | 1 | All three slots occupied |
| overrun_o | output | 1 | Sticky: an arriving frame met a full queue |

## Verification
The hardest situations to reach are a write that lands on a full queue in the same cycle as a release, and an overrun that coincides with a clear strobe. Both are single-cycle coincidences that ordinary streaming never lines up. The bench drives all strobes through one step task, so any mix of write, release and clear falls in the same cycle. It first fills the queue to exactly three frames and then fires the combined step. Each overrun case is then drained completely, so the surviving frame order (1, 2, 5 against 1, 2, 3) is seen at the read port.

// File: rtl/msg_rx_fifo_pkg.sv
package msg_rx_fifo_pkg;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic {
        POL_REPLACE_NEWEST = 1'b0,
        POL_DROP_ARRIVAL   = 1'b1
    } ovr_policy_e;

    // circular slot index helpers
    function automatic int unsigned slot_next(int unsigned p, int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

    function automatic int unsigned slot_prev(int unsigned p, int unsigned depth);
        return (p == 0) ? depth - 1 : p - 1;
    endfunction

endpackage

// File: rtl/msg_rx_fifo_ctrl.sv
module msg_rx_fifo_ctrl
    import msg_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ovr_policy_e      policy,
    input  logic             wr_req,
    input  logic             rel_req,
    output logic             slot_we,
    output logic [PTR_W-1:0] slot_waddr,
    output logic [PTR_W-1:0] head_ptr,
    output logic [LVL_W-1:0] level,
    output logic             ovr_evt
);

    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             has_head, is_full, do_pop, has_space, do_push, do_replace;
    logic [PTR_W-1:0] newest_ptr, wr_ptr_inc, rd_ptr_inc;

    always_comb begin
        has_head   = (level_q != '0);
        is_full    = (level_q == LVL_W'(DEPTH));
        do_pop     = rel_req && has_head;
        // a same-cycle release frees a slot before the write is judged
        has_space  = !is_full || do_pop;
        do_push    = wr_req && has_space;
        ovr_evt    = wr_req && !has_space;
        do_replace = ovr_evt && (policy == POL_REPLACE_NEWEST);
        newest_ptr = PTR_W'(slot_prev(int'(wr_ptr_q), DEPTH));
        wr_ptr_inc = PTR_W'(slot_next(int'(wr_ptr_q), DEPTH));
        rd_ptr_inc = PTR_W'(slot_next(int'(rd_ptr_q), DEPTH));
        slot_we    = do_push || do_replace;
        slot_waddr = do_push ? wr_ptr_q : newest_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_inc;
            if (do_pop)  rd_ptr_q <= rd_ptr_inc;
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign head_ptr = rd_ptr_q;
    assign level    = level_q;

endmodule

// File: rtl/msg_rx_fifo_store.sv
module msg_rx_fifo_store
    import msg_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  frame_t           wframe,
    input  logic [PTR_W-1:0] raddr,
    output frame_t           rframe
);

    frame_t slots [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[s] <= '0;
            else if (we && (waddr == PTR_W'(s)))
                slots[s] <= wframe;
        end
    end

    always_comb begin
        rframe = '0;
        for (int s = 0; s < DEPTH; s++)
            if (raddr == PTR_W'(s)) rframe = slots[s];
    end

endmodule

// File: rtl/msg_rx_fifo_flags.sv
module msg_rx_fifo_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovr_evt,
    input  logic ovr_clr,
    output logic overrun
);

    // a new event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (ovr_evt)
            overrun <= 1'b1;
        else if (ovr_clr)
            overrun <= 1'b0;
    end

endmodule

// File: rtl/msg_rx_fifo3.sv
module msg_rx_fifo3
    import msg_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_mode_i,
    input  logic              wr_en_i,
    input  logic [ID_W-1:0]   wr_id_i,
    input  logic [DLC_W-1:0]  wr_dlc_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rel_i,
    input  logic              ovr_clr_i,
    output logic              rd_valid_o,
    output logic [ID_W-1:0]   rd_id_o,
    output logic [DLC_W-1:0]  rd_dlc_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              overrun_o
);

    ovr_policy_e      policy;
    frame_t           in_frame, head_frame;
    logic             slot_we, ovr_evt;
    logic [PTR_W-1:0] slot_waddr, head_ptr;
    logic [LVL_W-1:0] level;

    assign policy   = lock_mode_i ? POL_DROP_ARRIVAL : POL_REPLACE_NEWEST;
    assign in_frame = '{id: wr_id_i, dlc: wr_dlc_i, data: wr_data_i};

    msg_rx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .policy     (policy),
        .wr_req     (wr_en_i),
        .rel_req    (rel_i),
        .slot_we    (slot_we),
        .slot_waddr (slot_waddr),
        .head_ptr   (head_ptr),
        .level      (level),
        .ovr_evt    (ovr_evt)
    );

    msg_rx_fifo_store #(.DEPTH(DEPTH)) store_i (
        .clk    (clk),
        .rst    (rst),
        .we     (slot_we),
        .waddr  (slot_waddr),
        .wframe (in_frame),
        .raddr  (head_ptr),
        .rframe (head_frame)
    );

    msg_rx_fifo_flags flags_i (
        .clk     (clk),
        .rst     (rst),
        .ovr_evt (ovr_evt),
        .ovr_clr (ovr_clr_i),
        .overrun (overrun_o)
    );

    always_comb begin
        rd_valid_o = (level != '0);
        rd_id_o    = rd_valid_o ? head_frame.id   : '0;
        rd_dlc_o   = rd_valid_o ? head_frame.dlc  : '0;
        rd_data_o  = rd_valid_o ? head_frame.data : '0;
        level_o    = level;
        full_o     = (level == LVL_W'(DEPTH));
    end

endmodule

// File: rtl/msg_rx_fifo3_chk.sv
module msg_rx_fifo3_chk
    import msg_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_mode_i,
    input logic              wr_en_i,
    input logic              rel_i,
    input logic              ovr_clr_i,
    input logic              rd_valid_o,
    input logic [ID_W-1:0]   rd_id_o,
    input logic [DLC_W-1:0]  rd_dlc_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [LVL_W-1:0]  level_o,
    input logic              full_o,
    input logic              overrun_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (level_o == '0 && !full_o && !overrun_o && !rd_valid_o));

    // R2
    push_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !rel_i && !full_o) |=> level_o == LVL_W'($past(level_o) + 1'b1));

    // R3
    pop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_i && !wr_en_i && rd_valid_o) |=> level_o == LVL_W'($past(level_o) - 1'b1));

    // R9
    ovr_level_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_en_i && !rel_i) |=> (full_o && overrun_o));

    // R5
    locked_head_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_mode_i && full_o && wr_en_i && !rel_i)
            |=> ($stable(rd_id_o) && $stable(rd_dlc_o) && $stable(rd_data_o)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !ovr_clr_i) |=> overrun_o);

    // R6
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> $past(full_o && wr_en_i && !rel_i));

    // R7
    swap_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_en_i && rel_i && !ovr_clr_i)
            |=> (full_o && overrun_o == $past(overrun_o)));

    // R8
    empty_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid_o && rel_i && !wr_en_i) |=> (level_o == '0 && !rd_valid_o));

endmodule

bind msg_rx_fifo3 msg_rx_fifo3_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/msg_rx_fifo3_tb_top.sv
module msg_rx_fifo3_tb_top;
    import msg_rx_fifo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lock_mode_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ID_W-1:0]   wr_id_i = '0;
    logic [DLC_W-1:0]  wr_dlc_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              rel_i = 1'b0;
    logic              ovr_clr_i = 1'b0;
    logic              rd_valid_o;
    logic [ID_W-1:0]   rd_id_o;
    logic [DLC_W-1:0]  rd_dlc_o;
    logic [DATA_W-1:0] rd_data_o;
    logic [1:0]        level_o;
    logic              full_o;
    logic              overrun_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msg_rx_fifo3 dut_i (.*);

    function automatic frame_t frame_of(int k);
        frame_t f;
        f.id   = ID_W'(k * 17 + 3);
        f.dlc  = DLC_W'(k % 9);
        f.data = {8{8'(k + 8'h40)}};
        return f;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle of strobes; entered and left at a falling edge
    task automatic step(input bit wr, input int k, input bit rel, input bit clr);
        frame_t f = frame_of(k);
        wr_en_i   = wr;
        wr_id_i   = f.id;
        wr_dlc_i  = f.dlc;
        wr_data_i = f.data;
        rel_i     = rel;
        ovr_clr_i = clr;
        @(negedge clk);
        wr_en_i   = 1'b0;
        rel_i     = 1'b0;
        ovr_clr_i = 1'b0;
    endtask

    task automatic check_head(input string req, input int k);
        frame_t f = frame_of(k);
        chk(req, "valid", 64'(rd_valid_o), 64'd1);
        chk(req, "id",    64'(rd_id_o),    64'(f.id));
        chk(req, "dlc",   64'(rd_dlc_o),   64'(f.dlc));
        chk(req, "data",  rd_data_o,       f.data);
    endtask

    task automatic drain_expect(input string req, input int a, input int b, input int c);
        int seq [3];
        seq = '{a, b, c};
        for (int i = 0; i < 3; i++) begin
            check_head(req, seq[i]);
            step(0, 0, 1, 0);
        end
        chk(req, "level after drain", 64'(level_o), 64'd0);
        chk(req, "valid after drain", 64'(rd_valid_o), 64'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "level",   64'(level_o),    64'd0);
        chk("R1", "full",    64'(full_o),     64'd0);
        chk("R1", "overrun", 64'(overrun_o),  64'd0);
        chk("R1", "valid",   64'(rd_valid_o), 64'd0);
    endtask

    task automatic t_order();
        lock_mode_i = 1'b0;
        step(1, 1, 0, 0);
        chk("R2", "level 1", 64'(level_o), 64'd1);
        check_head("R2", 1);
        step(1, 2, 0, 0);
        chk("R2", "level 2", 64'(level_o), 64'd2);
        chk("R2", "not full", 64'(full_o), 64'd0);
        step(1, 3, 0, 0);
        chk("R2", "level 3", 64'(level_o), 64'd3);
        chk("R2", "full", 64'(full_o), 64'd1);
        step(0, 0, 1, 0);
        chk("R3", "level after release", 64'(level_o), 64'd2);
        check_head("R3", 2);
        step(0, 0, 1, 0);
        check_head("R3", 3);
        step(0, 0, 1, 0);
        chk("R3", "empty", 64'(rd_valid_o), 64'd0);
    endtask

    task automatic t_over_default();
        do_reset();
        lock_mode_i = 1'b0;
        for (int k = 1; k <= 5; k++) step(1, k, 0, 0);
        chk("R9", "level after overrun", 64'(level_o), 64'd3);
        chk("R6", "overrun set", 64'(overrun_o), 64'd1);
        drain_expect("R4", 1, 2, 5);
        chk("R6", "sticky after drain", 64'(overrun_o), 64'd1);
        step(0, 0, 0, 1);
        chk("R6", "cleared", 64'(overrun_o), 64'd0);
    endtask

    task automatic t_over_locked();
        do_reset();
        lock_mode_i = 1'b1;
        for (int k = 1; k <= 3; k++) step(1, k, 0, 0);
        chk("R6", "no overrun before full write", 64'(overrun_o), 64'd0);
        step(1, 4, 0, 0);
        check_head("R5", 1);
        step(1, 5, 0, 0);
        chk("R9", "level locked", 64'(level_o), 64'd3);
        drain_expect("R5", 1, 2, 3);
        lock_mode_i = 1'b0;
    endtask

    task automatic t_clear_collide();
        do_reset();
        for (int k = 1; k <= 3; k++) step(1, k, 0, 0);
        step(1, 9, 0, 1);
        chk("R6", "set wins over clear", 64'(overrun_o), 64'd1);
        step(0, 0, 0, 1);
        chk("R6", "clear alone", 64'(overrun_o), 64'd0);
        drain_expect("R4", 1, 2, 9);
    endtask

    task automatic t_swap_full();
        do_reset();
        for (int k = 1; k <= 3; k++) step(1, k, 0, 0);
        step(1, 4, 1, 0);
        chk("R7", "level stays 3", 64'(level_o), 64'd3);
        chk("R7", "no overrun", 64'(overrun_o), 64'd0);
        drain_expect("R7", 2, 3, 4);
    endtask

    task automatic t_empty_release();
        do_reset();
        step(0, 0, 1, 0);
        chk("R8", "level after empty release", 64'(level_o), 64'd0);
        chk("R8", "valid after empty release", 64'(rd_valid_o), 64'd0);
        step(1, 7, 1, 0);
        chk("R8", "level after write+release on empty", 64'(level_o), 64'd1);
        check_head("R8", 7);
        step(1, 8, 0, 0);
        check_head("R8", 7);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_over_default();
        t_over_locked();
        t_clear_collide();
        t_swap_full();
        t_empty_release();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog R1..: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule